// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block produces the command stream that takes an SDRAM from power-up to a state where it can accept normal traffic. It sits between the chip's reset and clock logic and the memory pins. It is released by an input that reports a stable clock. It keeps the device deselected until that input is high. It then holds NOP while it counts out a 100 microsecond settling delay in clock cycles. After the delay it issues the fixed bring-up order: precharge of all banks, two auto-refresh commands and one load of the mode register. A parameter-set number of NOP cycles follows each of these commands.

When the gap after the mode load has elapsed, `init_done` goes high. The memory controller may then take over the pins. The sequencer keeps driving NOP until the next reset. Normal traffic, refresh scheduling and the memory device itself belong elsewhere.

The settling delay is 100 × `CLK_FREQ_MHZ` cycles. The gaps are `TRP_CYC`, `TRFC_CYC` and `TMRD_CYC` cycles, and each must be at least 1. The mode word (burst length, burst type, CAS latency) is the parameter `MODE_WORD`.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the pins show deselect (chip select high, encoding {cs_n,ras_n,cas_n,we_n} = 4'b1111), the address and bank lines are zero and `init_done` is low.
- R2: While `clk_stable` is low before the sequence starts, chip select stays high (deselect).
- R3: Once `clk_stable` is sampled high, NOP (4'b0111) is driven for exactly 100 × CLK_FREQ_MHZ + 1 consecutive cycles, and no other command appears before the precharge.
- R4: The first command after the wait is precharge (4'b0010) with address bit 10 high, all other address bits zero and the bank lines zero.
- R5: Exactly TRP_CYC NOP cycles follow the precharge, and then the first auto-refresh (4'b0001) is issued.
- R6: Exactly TRFC_CYC NOP cycles follow each auto-refresh. Exactly two auto-refreshes are issued, and after the second gap the next command is the mode load.
- R7: The mode load is encoded 4'b0000, drives MODE_WORD on the address bus and drives zero on the bank lines.
- R8: Exactly TMRD_CYC NOP cycles follow the mode load. In the next cycle `init_done` rises, and from then until reset it stays high while the pins show NOP.
- R9: If `clk_stable` falls during the wait, chip select goes high in the next cycle. The full 100 × CLK_FREQ_MHZ + 1 cycle NOP wait then restarts when `clk_stable` returns.
- R10: A reset asserted in the middle of the sequence returns the pins to the R1 state at once. After release, the full sequence runs again from the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_stable | input | 1 | High when the clock is within its limits |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (bit 10 selects all banks on precharge, mode word on load) |
| sd_ba | output | BA_W | Bank select |
| init_done | output | 1 | High once the device is ready |

## Verification
A wrong state or a wrong gap count shows on the command pins within one cycle. It appears as a NOP run of the wrong length or as a command out of order, so the bench measures every NOP run between commands exactly. A wait counter that is not cleared, or that is started early, lets the precharge arrive early or late. This appears only at the end of the 12,500-cycle wait, so the restart cases measure that whole run again. A wrong refresh count is visible as a third refresh or as a mode load one gap too early.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_TRFC,
        ST_MRS,
        ST_TMRD,
        ST_DONE
    } seq_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef logic [3:0] cmd_t;

    localparam cmd_t CMD_DESEL = 4'b1111;
    localparam cmd_t CMD_NOP   = 4'b0111;
    localparam cmd_t CMD_PRE   = 4'b0010;
    localparam cmd_t CMD_REF   = 4'b0001;
    localparam cmd_t CMD_MRS   = 4'b0000;

    localparam int PRE_ALL_BIT = 10;

endpackage

// File: rtl/sdram_init_wait_cnt.sv
module sdram_init_wait_cnt #(
    parameter int WAIT_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic expired
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (enable && (cnt_q != LIMIT)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIMIT);

    // R9: a loss of clock stability restarts the count
    p_clear_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/sdram_init_gap_cnt.sv
module sdram_init_gap_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(1));

    // R5: each gap starts from the full programmed length
    p_gap_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter int                BA_W      = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
    input  seq_state_e        state,
    output cmd_t              cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (state)
            ST_IDLE: cmd = CMD_DESEL;
            ST_PRE: begin
                cmd               = CMD_PRE;
                addr[PRE_ALL_BIT] = 1'b1;
            end
            ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = MODE_WORD;
            end
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int                CLK_FREQ_MHZ = 125,
    parameter int                TRP_CYC      = 3,
    parameter int                TRFC_CYC     = 9,
    parameter int                TMRD_CYC     = 2,
    parameter int                ADDR_W       = 13,
    parameter int                BA_W         = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD    = 'h033
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stable,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done
);
    localparam int WAIT_CYC = 100 * CLK_FREQ_MHZ;
    localparam int GAP_MAX1 = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
    localparam int GAP_MAX  = (GAP_MAX1 > TMRD_CYC) ? GAP_MAX1 : TMRD_CYC;
    localparam int GAP_W    = $clog2(GAP_MAX + 1);

    typedef struct packed {
        seq_state_e state;
        logic       ref_second;
        logic       done;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             wait_expired;
    logic             gap_last;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    cmd_t             cmd;

    sdram_init_wait_cnt #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!clk_stable),
        .enable  (seq_q.state == ST_WAIT),
        .expired (wait_expired)
    );

    sdram_init_gap_cnt #(.CW(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .last     (gap_last)
    );

    sdram_init_cmd_enc #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .MODE_WORD (MODE_WORD)
    ) u_enc (
        .state (seq_q.state),
        .cmd   (cmd),
        .addr  (sd_addr),
        .ba    (sd_ba)
    );

    // gap length is loaded while the command itself is on the pins
    always_comb begin
        gap_load = 1'b1;
        gap_val  = '0;
        unique case (seq_q.state)
            ST_PRE:  gap_val = GAP_W'(TRP_CYC);
            ST_REF:  gap_val = GAP_W'(TRFC_CYC);
            ST_MRS:  gap_val = GAP_W'(TMRD_CYC);
            default: gap_load = 1'b0;
        endcase
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: if (clk_stable) seq_d.state = ST_WAIT;
            ST_WAIT: begin
                if (!clk_stable)       seq_d.state = ST_IDLE;
                else if (wait_expired) seq_d.state = ST_PRE;
            end
            ST_PRE:  seq_d.state = ST_TRP;
            ST_TRP:  if (gap_last) seq_d.state = ST_REF;
            ST_REF:  seq_d.state = ST_TRFC;
            ST_TRFC: begin
                if (gap_last) begin
                    if (!seq_q.ref_second) begin
                        seq_d.state      = ST_REF;
                        seq_d.ref_second = 1'b1;
                    end else begin
                        seq_d.state = ST_MRS;
                    end
                end
            end
            ST_MRS:  seq_d.state = ST_TMRD;
            ST_TMRD: begin
                if (gap_last) begin
                    seq_d.state = ST_DONE;
                    seq_d.done  = 1'b1;
                end
            end
            default: seq_d.state = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, ref_second: 1'b0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign init_done = seq_q.done;

    // R2 / R9: instability before the sequence leaves the wait means deselect
    p_desel_unstable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_stable && (seq_q.state inside {ST_IDLE, ST_WAIT})) |=> sd_cs_n);

    // R3: precharge only after the full wait has been counted
    p_pre_after_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> $past(wait_expired));

    // R4: precharge targets all banks
    p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (sd_addr[PRE_ALL_BIT] && (sd_ba == '0)));

    // R6: every refresh follows a NOP gap
    p_ref_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> ($past(cmd) == CMD_NOP));

    // R7: mode load carries the mode word with banks at zero
    p_mrs_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> ((sd_addr == MODE_WORD) && (sd_ba == '0)));

    // R8: ready flag is sticky and the pins idle afterwards
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_done_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP));

endmodule

// File: tb/sim_sdram_powerup_seq.sv
module sim_sdram_powerup_seq;

    localparam int MHZ    = 125;
    localparam int WAIT_N = 100 * MHZ;
    localparam int T_RP   = 3;
    localparam int T_RFC  = 9;
    localparam int T_MRD  = 2;
    localparam int AW     = 13;
    localparam int BW     = 2;
    localparam logic [AW-1:0] MODE = 13'h033;

    localparam logic [3:0] C_DESEL = 4'b1111;
    localparam logic [3:0] C_NOP   = 4'b0111;
    localparam logic [3:0] C_PRE   = 4'b0010;
    localparam logic [3:0] C_REF   = 4'b0001;
    localparam logic [3:0] C_MRS   = 4'b0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_stable = 1'b0;
    logic          cs_n, ras_n, cas_n, we_n;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;
    logic          done;
    logic [3:0]    cmd;

    int checks = 0;
    int failures = 0;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always #4 clk = ~clk;

    sdram_powerup_seq #(
        .CLK_FREQ_MHZ (MHZ),
        .TRP_CYC      (T_RP),
        .TRFC_CYC     (T_RFC),
        .TMRD_CYC     (T_MRD),
        .ADDR_W       (AW),
        .BA_W         (BW),
        .MODE_WORD    (MODE)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_stable (clk_stable),
        .sd_cs_n    (cs_n),
        .sd_ras_n   (ras_n),
        .sd_cas_n   (cas_n),
        .sd_we_n    (we_n),
        .sd_addr    (addr),
        .sd_ba      (ba),
        .init_done  (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clk_stable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic count_nops(output int n);
        n = 0;
        while (cmd == C_NOP && !done && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_reset_state(input string req);
        chk(cmd == C_DESEL, req, cmd, C_DESEL);
        chk(addr == '0 && ba == '0, req, addr, 0);
        chk(done == 1'b0, req, done, 0);
    endtask

    task automatic test_full_sequence();
        int n;
        bit desel_ok;
        bit stay_ok;
        do_reset();
        check_reset_state("R1");
        desel_ok = 1'b1;
        repeat (6) begin
            @(negedge clk);
            if (cs_n !== 1'b1) desel_ok = 1'b0;
        end
        chk(desel_ok, "R2", desel_ok, 1);
        clk_stable = 1'b1;
        @(negedge clk);
        count_nops(n);
        chk(n == WAIT_N + 1, "R3", n, WAIT_N + 1);
        chk(cmd == C_PRE, "R4", cmd, C_PRE);
        chk(addr == (AW'(1) << 10) && ba == '0, "R4", addr, 1 << 10);
        @(negedge clk);
        count_nops(n);
        chk(n == T_RP, "R5", n, T_RP);
        chk(cmd == C_REF, "R5", cmd, C_REF);
        @(negedge clk);
        count_nops(n);
        chk(n == T_RFC, "R6", n, T_RFC);
        chk(cmd == C_REF, "R6", cmd, C_REF);
        @(negedge clk);
        count_nops(n);
        chk(n == T_RFC, "R6", n, T_RFC);
        chk(cmd == C_MRS, "R7", cmd, C_MRS);
        chk(addr == MODE && ba == '0, "R7", addr, MODE);
        @(negedge clk);
        count_nops(n);
        chk(n == T_MRD, "R8", n, T_MRD);
        chk(done == 1'b1 && cmd == C_NOP, "R8", done, 1);
        stay_ok = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (done !== 1'b1 || cmd !== C_NOP) stay_ok = 1'b0;
        end
        chk(stay_ok, "R8", stay_ok, 1);
    endtask

    task automatic test_stable_drop();
        int n;
        do_reset();
        clk_stable = 1'b1;
        repeat (40) @(negedge clk);
        chk(cmd == C_NOP, "R3", cmd, C_NOP);
        clk_stable = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R9", cs_n, 1);
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R9", cs_n, 1);
        clk_stable = 1'b1;
        @(negedge clk);
        count_nops(n);
        chk(n == WAIT_N + 1, "R9", n, WAIT_N + 1);
        chk(cmd == C_PRE, "R9", cmd, C_PRE);
    endtask

    task automatic test_reset_mid();
        int n;
        int guard;
        do_reset();
        clk_stable = 1'b1;
        guard = 0;
        while (cmd != C_REF && guard < 20000) begin
            guard++;
            @(negedge clk);
        end
        chk(cmd == C_REF, "R10", cmd, C_REF);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("R10");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        count_nops(n);
        chk(n == WAIT_N + 1, "R10", n, WAIT_N + 1);
        chk(cmd == C_PRE, "R10", cmd, C_PRE);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        test_full_sequence();
        test_stable_drop();
        test_reset_mid();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule